// File: doc/BRIEF.md
# Partition Freeze Filter

This block holds a table of freeze flags for every isolation partition and uses it to screen tagged traffic. Each partition owns two flags: one covers the memory-mapped I/O path and one covers the DMA path. The error-report port raises both flags of one partition in a single cycle. The software clear port lowers either flag, or both, on its own.

Every transaction carries a partition number, a type code and a data word. The filter looks up the flag that governs that type and then does one of three things. It forwards the transaction unchanged. It discards it and counts the drop. Or, for a read, it completes it locally with an all-ones word. Results appear one clock after the transaction is presented. The lookup uses the flag values held before that same clock edge's updates.

Top module: `pe_freeze_filter`

## Requirements
- R1: After synchronous reset, every flag is clear, both drop counters read zero and no forward or synthetic output is valid.
- R2: A freeze event (`frz_valid` with `frz_part`) sets the MMIO flag and the DMA flag of that partition on the same clock edge.
- R3: A software clear lowers the MMIO flag when `clr_mmio` is 1 and the DMA flag when `clr_dma` is 1. A flag whose bit is 0 keeps its value.
- R4: When a freeze event and a software clear name the same partition in the same cycle, both flags end up set.
- R5: Type codes are: 0 MMIO load, 1 MMIO store, 2 DMA read, 3 DMA write, 4 MSI. Type 1 with the MMIO flag set, or type 3 with the DMA flag set, produces no output.
- R6: Type 0 with the MMIO flag set, or type 2 with the DMA flag set, produces `syn_valid` one cycle later with `syn_data` all ones, the same partition and type, and no forward.
- R7: An MSI (type 4) from a partition whose DMA flag is set produces no output.
- R8: Types 0 and 1 consult only the MMIO flag. Types 2, 3 and 4 consult only the DMA flag.
- R9: A transaction whose governing flag is clear appears on the forward outputs one cycle later, with type, partition and data unchanged.
- R10: `drop_mmio` counts discarded type-1 transactions. `drop_dma` counts discarded type-3 and type-4 transactions. Each counter saturates at its all-ones value.
- R11: All 2^PART_W partitions are kept apart: flags of partition 0 and partition 255 change only through events that name them.
- R12: Type codes 5 to 7 produce no output and change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frz_valid | input | 1 | Freeze event strobe |
| frz_part | input | PART_W | Partition to freeze |
| clr_valid | input | 1 | Software clear strobe |
| clr_part | input | PART_W | Partition to clear |
| clr_mmio | input | 1 | Clear the MMIO flag |
| clr_dma | input | 1 | Clear the DMA flag |
| txn_valid | input | 1 | Transaction present |
| txn_kind | input | 3 | Transaction type code |
| txn_part | input | PART_W | Transaction partition number |
| txn_data | input | DATA_W | Transaction data or address word |
| fwd_valid | output | 1 | Forwarded transaction valid |
| fwd_kind | output | 3 | Forwarded type code |
| fwd_part | output | PART_W | Forwarded partition |
| fwd_data | output | DATA_W | Forwarded data |
| syn_valid | output | 1 | Synthetic read completion valid |
| syn_kind | output | 3 | Type of the completed read |
| syn_part | output | PART_W | Partition of the completed read |
| syn_data | output | DATA_W | Completion data, all ones |
| drop_mmio | output | CNT_W | Discarded MMIO store count |
| drop_dma | output | CNT_W | Discarded DMA write and MSI count |

## Verification
Some properties are checked on every cycle. A freeze event must leave both flags set. A one-sided clear must leave the other flag untouched. A frozen store must yield no output and a frozen read must yield an all-ones completion. The drop counters must never move backwards. Only the bench scenarios can show the rest: the set-over-clear priority, that the two paths are selected independently per type, that partitions at the two ends of the table stay apart, that reserved codes are ignored, and that the counters saturate.

// File: rtl/pe_freeze_pkg.sv
package pe_freeze_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_MMIO_LD = 3'd0,
        K_MMIO_ST = 3'd1,
        K_DMA_RD  = 3'd2,
        K_DMA_WR  = 3'd3,
        K_MSI     = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FWD   = 2'd1,
        ACT_SYNTH = 2'd2,
        ACT_DROP  = 2'd3
    } act_e;

    function automatic logic kind_is_mmio(input logic [KIND_W-1:0] k);
        return (k == K_MMIO_LD) || (k == K_MMIO_ST);
    endfunction

    function automatic logic kind_is_dma(input logic [KIND_W-1:0] k);
        return (k == K_DMA_RD) || (k == K_DMA_WR) || (k == K_MSI);
    endfunction

    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == K_MMIO_LD) || (k == K_DMA_RD);
    endfunction
endpackage

// File: rtl/pe_freeze_table.sv
module pe_freeze_table
    import pe_freeze_pkg::*;
#(
    parameter int PART_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frz_valid,
    input  logic [PART_W-1:0] frz_part,
    input  logic              clr_valid,
    input  logic [PART_W-1:0] clr_part,
    input  logic              clr_mmio,
    input  logic              clr_dma,
    input  logic [PART_W-1:0] rd_part,
    output logic              rd_mmio,
    output logic              rd_dma
);
    localparam int NUM_PART = 1 << PART_W;

    logic [NUM_PART-1:0] mmio_q, dma_q;
    logic [NUM_PART-1:0] set_v, clrm_v, clrd_v;

    for (genvar i = 0; i < NUM_PART; i++) begin : g_entry
        assign set_v[i]  = frz_valid && (frz_part == PART_W'(i));
        assign clrm_v[i] = clr_valid && clr_mmio && (clr_part == PART_W'(i));
        assign clrd_v[i] = clr_valid && clr_dma  && (clr_part == PART_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mmio_q <= '0;
            dma_q  <= '0;
        end else begin
            mmio_q <= (mmio_q & ~clrm_v) | set_v;
            dma_q  <= (dma_q  & ~clrd_v) | set_v;
        end
    end

    assign rd_mmio = mmio_q[rd_part];
    assign rd_dma  = dma_q[rd_part];

    // R2
    freeze_both_chk: assert property (@(posedge clk) disable iff (rst)
        frz_valid |=> (mmio_q[$past(frz_part)] && dma_q[$past(frz_part)]));

    // R3
    clear_keep_dma_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && clr_mmio && !clr_dma && !(frz_valid && frz_part == clr_part))
        |=> (dma_q[$past(clr_part)] == $past(dma_q[clr_part])));
endmodule

// File: rtl/pe_freeze_classify.sv
module pe_freeze_classify
    import pe_freeze_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic              frozen_mmio,
    input  logic              frozen_dma,
    output act_e              act,
    output logic              drop_m,
    output logic              drop_d
);
    logic frozen;

    always_comb begin
        frozen = 1'b0;
        if (kind_is_mmio(kind)) frozen = frozen_mmio;
        else if (kind_is_dma(kind)) frozen = frozen_dma;

        act    = ACT_NONE;
        drop_m = 1'b0;
        drop_d = 1'b0;
        if (valid && (kind_is_mmio(kind) || kind_is_dma(kind))) begin
            if (!frozen)                 act = ACT_FWD;
            else if (kind_is_read(kind)) act = ACT_SYNTH;
            else begin
                act    = ACT_DROP;
                drop_m = kind_is_mmio(kind);
                drop_d = kind_is_dma(kind);
            end
        end
    end
endmodule

// File: rtl/pe_sat_counter.sv
module pe_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/pe_freeze_filter.sv
module pe_freeze_filter
    import pe_freeze_pkg::*;
#(
    parameter int PART_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frz_valid,
    input  logic [PART_W-1:0] frz_part,
    input  logic              clr_valid,
    input  logic [PART_W-1:0] clr_part,
    input  logic              clr_mmio,
    input  logic              clr_dma,
    input  logic              txn_valid,
    input  logic [2:0]        txn_kind,
    input  logic [PART_W-1:0] txn_part,
    input  logic [DATA_W-1:0] txn_data,
    output logic              fwd_valid,
    output logic [2:0]        fwd_kind,
    output logic [PART_W-1:0] fwd_part,
    output logic [DATA_W-1:0] fwd_data,
    output logic              syn_valid,
    output logic [2:0]        syn_kind,
    output logic [PART_W-1:0] syn_part,
    output logic [DATA_W-1:0] syn_data,
    output logic [CNT_W-1:0]  drop_mmio,
    output logic [CNT_W-1:0]  drop_dma
);
    logic rd_mmio, rd_dma;
    act_e act;
    logic drop_m, drop_d;

    pe_freeze_table #(.PART_W(PART_W)) u_table (
        .clk(clk), .rst(rst),
        .frz_valid(frz_valid), .frz_part(frz_part),
        .clr_valid(clr_valid), .clr_part(clr_part),
        .clr_mmio(clr_mmio), .clr_dma(clr_dma),
        .rd_part(txn_part), .rd_mmio(rd_mmio), .rd_dma(rd_dma)
    );

    pe_freeze_classify u_cls (
        .valid(txn_valid), .kind(txn_kind),
        .frozen_mmio(rd_mmio), .frozen_dma(rd_dma),
        .act(act), .drop_m(drop_m), .drop_d(drop_d)
    );

    pe_sat_counter #(.CNT_W(CNT_W)) u_cnt_mmio (
        .clk(clk), .rst(rst), .inc(drop_m), .count(drop_mmio)
    );

    pe_sat_counter #(.CNT_W(CNT_W)) u_cnt_dma (
        .clk(clk), .rst(rst), .inc(drop_d), .count(drop_dma)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_kind  <= '0;
            fwd_part  <= '0;
            fwd_data  <= '0;
            syn_valid <= 1'b0;
            syn_kind  <= '0;
            syn_part  <= '0;
            syn_data  <= '0;
        end else begin
            fwd_valid <= (act == ACT_FWD);
            syn_valid <= (act == ACT_SYNTH);
            if (act == ACT_FWD) begin
                fwd_kind <= txn_kind;
                fwd_part <= txn_part;
                fwd_data <= txn_data;
            end
            if (act == ACT_SYNTH) begin
                syn_kind <= txn_kind;
                syn_part <= txn_part;
                syn_data <= '1;
            end
        end
    end

    // R5
    frozen_store_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && ((txn_kind == K_MMIO_ST && rd_mmio) || (txn_kind == K_DMA_WR && rd_dma)))
        |=> (!fwd_valid && !syn_valid));

    // R6
    frozen_load_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && ((txn_kind == K_MMIO_LD && rd_mmio) || (txn_kind == K_DMA_RD && rd_dma)))
        |=> (syn_valid && !fwd_valid && syn_data == {DATA_W{1'b1}}));

    // R7
    msi_block_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_kind == K_MSI && rd_dma) |=> !fwd_valid);

    // R10
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_mmio >= $past(drop_mmio)) && (drop_dma >= $past(drop_dma)));
endmodule

// File: tb/tb_pe_freeze_filter.sv
module tb_pe_freeze_filter;
    localparam int PART_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frz_valid = 0, clr_valid = 0, clr_mmio = 0, clr_dma = 0, txn_valid = 0;
    logic [PART_W-1:0] frz_part = '0, clr_part = '0, txn_part = '0;
    logic [2:0] txn_kind = '0;
    logic [DATA_W-1:0] txn_data = '0;
    logic fwd_valid, syn_valid;
    logic [2:0] fwd_kind, syn_kind;
    logic [PART_W-1:0] fwd_part, syn_part;
    logic [DATA_W-1:0] fwd_data, syn_data;
    logic [CNT_W-1:0] drop_mmio, drop_dma;

    always #2.5 clk = ~clk;

    pe_freeze_filter #(.PART_W(PART_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst),
        .frz_valid(frz_valid), .frz_part(frz_part),
        .clr_valid(clr_valid), .clr_part(clr_part),
        .clr_mmio(clr_mmio), .clr_dma(clr_dma),
        .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_part(txn_part), .txn_data(txn_data),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_part(fwd_part), .fwd_data(fwd_data),
        .syn_valid(syn_valid), .syn_kind(syn_kind), .syn_part(syn_part), .syn_data(syn_data),
        .drop_mmio(drop_mmio), .drop_dma(drop_dma)
    );

    typedef struct {
        int          cyc;
        int          outcome;   // 0 none, 1 forward, 2 synthetic
        logic [2:0]  kind;
        logic [PART_W-1:0] part;
        logic [DATA_W-1:0] data;
        int          cm;
        int          cd;
        string       req;
    } exp_t;

    exp_t sb[$];
    bit   mf[256];
    bit   df[256];
    int   cnt_m = 0, cnt_d = 0;
    int   cyc = 0;
    int   checks = 0, fails = 0;
    bit   mon_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic freeze(input int p);
        @(negedge clk);
        frz_valid = 1; frz_part = PART_W'(p);
        mf[p] = 1; df[p] = 1;
        @(posedge clk); #1 frz_valid = 0;
    endtask

    task automatic clear(input int p, input bit m, input bit d);
        @(negedge clk);
        clr_valid = 1; clr_part = PART_W'(p); clr_mmio = m; clr_dma = d;
        if (m) mf[p] = 0;
        if (d) df[p] = 0;
        @(posedge clk); #1 clr_valid = 0; clr_mmio = 0; clr_dma = 0;
    endtask

    task automatic freeze_and_clear(input int p);
        @(negedge clk);
        frz_valid = 1; frz_part = PART_W'(p);
        clr_valid = 1; clr_part = PART_W'(p); clr_mmio = 1; clr_dma = 1;
        mf[p] = 1; df[p] = 1;
        @(posedge clk); #1 frz_valid = 0; clr_valid = 0; clr_mmio = 0; clr_dma = 0;
    endtask

    task automatic send(input int k, input int p, input logic [DATA_W-1:0] d, input string req);
        exp_t e;
        bit fz;
        @(negedge clk);
        txn_valid = 1; txn_kind = 3'(k); txn_part = PART_W'(p); txn_data = d;
        e.cyc = cyc; e.kind = 3'(k); e.part = PART_W'(p); e.data = d; e.req = req;
        fz = (k <= 1) ? mf[p] : df[p];
        if (k > 4)        e.outcome = 0;
        else if (!fz)     e.outcome = 1;
        else if (k == 0 || k == 2) begin
            e.outcome = 2; e.data = '1;
        end else begin
            e.outcome = 0;
            if (k == 1) begin if (cnt_m < CMAX) cnt_m++; end
            else        begin if (cnt_d < CMAX) cnt_d++; end
        end
        e.cm = cnt_m; e.cd = cnt_d;
        sb.push_back(e);
        @(posedge clk); #1 txn_valid = 0;
    endtask

    // Monitor: pops the item driven in the previous cycle and compares
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].cyc == cyc - 1) begin
                exp_t e;
                e = sb.pop_front();
                chk(fwd_valid == (e.outcome == 1), e.req, "fwd_valid", fwd_valid, e.outcome == 1);
                chk(syn_valid == (e.outcome == 2), e.req, "syn_valid", syn_valid, e.outcome == 2);
                if (e.outcome == 1)
                    chk(fwd_kind == e.kind && fwd_part == e.part && fwd_data == e.data,
                        e.req, "fwd_data", fwd_data, e.data);
                if (e.outcome == 2)
                    chk(syn_kind == e.kind && syn_part == e.part && syn_data == e.data,
                        e.req, "syn_data", syn_data, e.data);
                chk(int'(drop_mmio) == e.cm, e.req, "drop_mmio (R10)", drop_mmio, e.cm);
                chk(int'(drop_dma) == e.cd, e.req, "drop_dma (R10)", drop_dma, e.cd);
            end else begin
                chk(!fwd_valid && !syn_valid, "R9", "spurious output", {fwd_valid, syn_valid}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(!fwd_valid && !syn_valid, "R1", "outputs after reset", {fwd_valid, syn_valid}, 0);
        chk(drop_mmio == 0 && drop_dma == 0, "R1", "counters after reset", {drop_mmio, drop_dma}, 0);
        mon_on = 1;

        // R9 / R1: nothing frozen, all types pass
        for (int k = 0; k < 5; k++) send(k, 3, 32'h1000 + k, "R9");

        // R2: freeze sets both paths
        freeze(3);
        send(0, 3, 32'hA0, "R6");
        send(1, 3, 32'hA1, "R5");
        send(2, 3, 32'hA2, "R6");
        send(3, 3, 32'hA3, "R5");
        send(4, 3, 32'hA4, "R7");
        send(1, 4, 32'hB1, "R11");

        // R3: separate clears
        clear(3, 1, 0);
        send(0, 3, 32'hC0, "R3");
        send(2, 3, 32'hC2, "R3");
        clear(3, 0, 1);
        send(2, 3, 32'hC4, "R3");
        send(4, 3, 32'hC5, "R3");

        // R4: set beats clear
        freeze_and_clear(3);
        send(0, 3, 32'hD0, "R4");
        send(3, 3, 32'hD3, "R4");

        // R8: only DMA cleared, MMIO stays frozen
        freeze(10);
        clear(10, 0, 1);
        send(1, 10, 32'hE1, "R8");
        send(4, 10, 32'hE4, "R8");
        send(0, 10, 32'hE0, "R8");

        // R11: table ends
        freeze(255);
        send(0, 0, 32'hF0, "R11");
        send(0, 255, 32'hF1, "R11");
        send(4, 255, 32'hF4, "R11");

        // R12: reserved codes
        for (int k = 5; k < 8; k++) send(k, 0, 32'h5500 + k, "R12");

        // R10: saturation of the MMIO drop counter
        for (int i = 0; i < CMAX + 3; i++) send(1, 255, 32'h77, "R10");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule